// File: doc/BRIEF.md
# Trace ID Stream Filter

This block sits between one trace stream and two trace sinks and decides, beat by beat, which sinks see each beat. Every beat carries a 7-bit trace ID next to its 32-bit data word. Each sink owns a 128-bit allow mask with one bit per ID. A beat goes to a sink only when that sink's bit for the beat's ID is set. A sink whose bit is clear never sees the beat. A beat that no sink wants is consumed at once, so the input is never stalled by it.

The masks are reached through an APB-style register port. Each sink's mask appears as four 32-bit words. A key register gates all mask writes. Software opens the gate with the key, updates a word with read-modify-write to enable or disable one source's ID, and then closes the gate again.

Top module: `trace_id_gate`

## Requirements
- R1: After reset every mask bit is 0, the unit is locked, and no beat reaches any sink.
- R2: A beat with a non-reserved ID `i` raises `sinkValid[s]` with `sinkData`/`sinkId` equal to the input exactly when bit `i % 32` of word `i / 32` of sink `s` is 1.
- R3: Word `w` (0..3) of sink `s` (0..1) lives at byte address 0x0F8 + 0x10*s + 4*w. A write replaces the whole word and reads return it.
- R4: Reads from any other address return 0. This includes addresses in the mask range that are not word-aligned. Writes to any other address change no mask bit.
- R5: A write of 0xC5ACCE55 to address 0xFB0 unlocks the unit. A write of any other value to 0xFB0 locks it.
- R6: Beats with ID 0 or with an ID from 0x70 to 0x7F never reach a sink, whatever the masks hold.
- R7: A mask write made while locked is ignored, and the word reads back unchanged.
- R8: `inReady` is 1 exactly when every sink that accepts the current beat has `sinkReady` set. `sinkValid[s]` is raised only when every other accepting sink is ready, so each accepting sink takes the beat in the same cycle.
- R9: A mask write takes effect in the cycle after its access phase. The beat on the input during the access phase still uses the old mask.
- R10: Every register access completes in its first access cycle. `pReady` is always 1, and read data is valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pSel | input | 1 | Register port select |
| pEnable | input | 1 | Register port access phase |
| pWrite | input | 1 | 1 = write, 0 = read |
| pAddr | input | 12 | Byte address |
| pWdata | input | 32 | Write data |
| pRdata | output | 32 | Read data, 0 when not a mapped read |
| pReady | output | 1 | Access complete, always 1 |
| inValid | input | 1 | Input beat valid |
| inId | input | 7 | Input beat trace ID |
| inData | input | 32 | Input beat data |
| inReady | output | 1 | Input beat consumed |
| sinkValid | output | 2 | Per-sink beat valid |
| sinkData | output | 32 | Beat data broadcast to sinks |
| sinkId | output | 7 | Beat ID broadcast to sinks |
| sinkReady | input | 2 | Per-sink ready |

## Verification
A mask write and a beat can fall in the same cycle. The bench holds a beat whose ID is currently blocked on the input while the write that enables it goes through its access phase. It expects the sink valid to stay low during the access phase and to rise in the following cycle. Filtering and back-pressure also combine: every ID is swept under all four sink-ready patterns, and the expected valid and ready values are derived from the bench's own model of the masks.

// File: rtl/tig_pkg.sv
package tig_pkg;
  localparam int NumSinks     = 2;
  localparam int IdW          = 7;
  localparam int RegW         = 32;
  localparam int NumIds       = 1 << IdW;
  localparam int WordsPerSink = NumIds / RegW;
  localparam int WordSelW     = $clog2(WordsPerSink);
  localparam int BitSelW      = $clog2(RegW);
  localparam int SinkSelW     = (NumSinks > 1) ? $clog2(NumSinks) : 1;
  localparam logic [IdW-1:0] ResvFirst = 7'h70;

  typedef struct packed {
    logic                wrEn;
    logic                rdHit;
    logic [SinkSelW-1:0] sinkSel;
    logic [WordSelW-1:0] wordSel;
    logic [RegW-1:0]     wrData;
  } tig_strobe_t;
endpackage

// File: rtl/tig_ctrl.sv
module tig_ctrl
  import tig_pkg::*;
#(
  parameter int              AddrW     = 12,
  parameter logic [AddrW-1:0] MaskBase = 12'h0F8,
  parameter logic [AddrW-1:0] LockAddr = 12'hFB0,
  parameter logic [RegW-1:0]  UnlockKey = 32'hC5AC_CE55
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pSel,
  input  logic             pEnable,
  input  logic             pWrite,
  input  logic [AddrW-1:0] pAddr,
  input  logic [RegW-1:0]  pWdata,
  output tig_strobe_t      strobe,
  output logic             locked
);
  localparam int ByteOffW = $clog2(RegW / 8);
  localparam logic [AddrW-1:0] MaskSpan =
    AddrW'(NumSinks * WordsPerSink * (RegW / 8));

  logic             access;
  logic             inMask;
  logic [AddrW-1:0] offset;

  assign access = pSel & pEnable;
  assign offset = pAddr - MaskBase;
  assign inMask = (pAddr >= MaskBase) && (offset < MaskSpan) &&
                  (offset[ByteOffW-1:0] == '0);

  // Key register: always writable, reset to locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (access && pWrite && (pAddr == LockAddr)) begin
      locked <= (pWdata != UnlockKey);
    end
  end

  always_comb begin
    strobe.wrEn    = access & pWrite & inMask & ~locked;
    strobe.rdHit   = access & ~pWrite & inMask;
    strobe.sinkSel = offset[ByteOffW+WordSelW +: SinkSelW];
    strobe.wordSel = offset[ByteOffW +: WordSelW];
    strobe.wrData  = pWdata;
  end
endmodule

// File: rtl/tig_datapath.sv
module tig_datapath
  import tig_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  tig_strobe_t         strobe,
  output logic [RegW-1:0]     pRdata,
  input  logic                inValid,
  input  logic [IdW-1:0]      inId,
  input  logic [DataW-1:0]    inData,
  output logic                inReady,
  output logic [NumSinks-1:0] sinkValid,
  output logic [DataW-1:0]    sinkData,
  output logic [IdW-1:0]      sinkId,
  input  logic [NumSinks-1:0] sinkReady
);
  logic [NumSinks-1:0][NumIds-1:0] maskQ;
  logic [NumSinks-1:0] accept;
  logic [NumSinks-1:0] blockVec;
  logic [IdW-1:0]      rdBase;
  logic                idReserved;

  // Mask storage: whole-word writes only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.wrEn) begin
      for (int s = 0; s < NumSinks; s++) begin
        for (int w = 0; w < WordsPerSink; w++) begin
          if ((strobe.sinkSel == SinkSelW'(s)) && (strobe.wordSel == WordSelW'(w))) begin
            maskQ[s][w*RegW +: RegW] <= strobe.wrData;
          end
        end
      end
    end
  end

  assign rdBase = {strobe.wordSel, {BitSelW{1'b0}}};

  always_comb begin
    pRdata = '0;
    if (strobe.rdHit) begin
      pRdata = maskQ[strobe.sinkSel][rdBase +: RegW];
    end
  end

  assign idReserved = (inId == '0) || (inId >= ResvFirst);

  for (genvar s = 0; s < NumSinks; s++) begin : g_sink
    localparam logic [NumSinks-1:0] SelfBit = NumSinks'(1) << s;
    assign accept[s]    = maskQ[s][inId] & ~idReserved;
    assign blockVec[s]  = accept[s] & ~sinkReady[s];
    assign sinkValid[s] = inValid & accept[s] & ~|(blockVec & ~SelfBit);
  end

  assign inReady  = ~|blockVec;
  assign sinkData = inData;
  assign sinkId   = inId;
endmodule

// File: rtl/trace_id_gate.sv
module trace_id_gate
  import tig_pkg::*;
#(
  parameter int               AddrW     = 12,
  parameter int               DataW     = 32,
  parameter logic [AddrW-1:0] MaskBase  = 12'h0F8,
  parameter logic [AddrW-1:0] LockAddr  = 12'hFB0,
  parameter logic [RegW-1:0]  UnlockKey = 32'hC5AC_CE55
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pSel,
  input  logic                pEnable,
  input  logic                pWrite,
  input  logic [AddrW-1:0]    pAddr,
  input  logic [RegW-1:0]     pWdata,
  output logic [RegW-1:0]     pRdata,
  output logic                pReady,
  input  logic                inValid,
  input  logic [IdW-1:0]      inId,
  input  logic [DataW-1:0]    inData,
  output logic                inReady,
  output logic [NumSinks-1:0] sinkValid,
  output logic [DataW-1:0]    sinkData,
  output logic [IdW-1:0]      sinkId,
  input  logic [NumSinks-1:0] sinkReady
);
  tig_strobe_t strobe;
  logic        locked;

  assign pReady = 1'b1;

  tig_ctrl #(
    .AddrW(AddrW), .MaskBase(MaskBase), .LockAddr(LockAddr), .UnlockKey(UnlockKey)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .strobe(strobe), .locked(locked)
  );

  tig_datapath #(.DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pRdata(pRdata),
    .inValid(inValid), .inId(inId), .inData(inData), .inReady(inReady),
    .sinkValid(sinkValid), .sinkData(sinkData), .sinkId(sinkId),
    .sinkReady(sinkReady)
  );
endmodule

// File: rtl/tig_checker.sv
module tig_checker (
  input logic        clk,
  input logic        rstN,
  input logic        pSel,
  input logic        pEnable,
  input logic        pWrite,
  input logic [11:0] pAddr,
  input logic [31:0] pWdata,
  input logic [31:0] pRdata,
  input logic        inValid,
  input logic [6:0]  inId,
  input logic        inReady,
  input logic [1:0]  sinkValid,
  input logic [1:0]  sinkReady,
  input logic        locked
);
  logic pastValid;
  logic unmapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign unmapped = (pAddr < 12'h0F8) || (pAddr >= 12'h118) || (pAddr[1:0] != 2'b00);

  a_r6_reserved_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (inId == 7'd0 || inId >= 7'h70) |-> (sinkValid == 2'b00));

  a_r8_ready_means_taken: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ((sinkValid & ~sinkReady) == 2'b00));

  a_r2_valid_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    (sinkValid != 2'b00) |-> inValid);

  a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pWrite && unmapped) |-> (pRdata == 32'h0));

  a_r5_relock: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pSel && pEnable && pWrite && pAddr == 12'hFB0 &&
                        pWdata != 32'hC5AC_CE55)) |-> locked);

  a_r5_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pSel && pEnable && pWrite && pAddr == 12'hFB0 &&
                        pWdata == 32'hC5AC_CE55)) |-> !locked);
endmodule

bind trace_id_gate tig_checker u_chk (
  .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
  .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .inValid(inValid),
  .inId(inId), .inReady(inReady), .sinkValid(sinkValid),
  .sinkReady(sinkReady), .locked(locked)
);

// File: tb/sim_trace_id_gate.sv
`timescale 1ns/1ps
module sim_trace_id_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [11:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady;
  logic        inValid = 1'b0;
  logic [6:0]  inId = '0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic [1:0]  sinkValid;
  logic [31:0] sinkData;
  logic [6:0]  sinkId;
  logic [1:0]  sinkReady = 2'b11;

  int nChecks = 0;
  int nErrors = 0;
  logic [127:0] expMask [2];
  logic         expLocked;
  bit           done = 1'b0;

  localparam logic [31:0] Key = 32'hC5AC_CE55;

  always #2.5 clk = ~clk;

  trace_id_gate u0 (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .inValid(inValid), .inId(inId), .inData(inData), .inReady(inReady),
    .sinkValid(sinkValid), .sinkData(sinkData), .sinkId(sinkId),
    .sinkReady(sinkReady)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit isMapped(input logic [11:0] a);
    return (a >= 12'h0F8) && (a < 12'h118) && (a[1:0] == 2'b00);
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'hFB0) begin
      expLocked = (d != Key);
    end else if (isMapped(a) && !expLocked) begin
      int off = int'(a) - 'hF8;
      expMask[off / 16][((off % 16) / 4) * 32 +: 32] = d;
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pAddr = a; pWdata = d; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b0; pAddr = a; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    #1;
    d = pRdata;
    chk("R10", "pReady in access", {31'b0, pReady}, 32'h1);
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0;
  endtask

  task automatic readAll(input string req);
    logic [31:0] d;
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 4; w++) begin
        apbRead(12'(12'h0F8 + 16 * s + 4 * w), d);
        chk(req, $sformatf("readback sink%0d word%0d", s, w), d, expMask[s][w*32 +: 32]);
      end
    end
  endtask

  task automatic sweepIds(input logic [1:0] rdy);
    for (int id = 0; id < 128; id++) begin
      logic [1:0] acc, blk, ev;
      bit resv;
      @(negedge clk);
      inValid = 1'b1; inId = 7'(id); inData = 32'h9E37_79B9 * (id + 3); sinkReady = rdy;
      #1;
      resv = (id == 0) || (id >= 'h70);
      for (int s = 0; s < 2; s++) acc[s] = expMask[s][id] && !resv;
      blk = acc & ~rdy;
      ev[0] = acc[0] && !blk[1];
      ev[1] = acc[1] && !blk[0];
      chk(resv ? "R6" : "R2", $sformatf("sinkValid id %0d rdy %0d", id, rdy),
          {30'b0, sinkValid}, {30'b0, ev});
      chk("R8", $sformatf("inReady id %0d rdy %0d", id, rdy),
          {31'b0, inReady}, {31'b0, (blk == 2'b00)});
      if (ev != 2'b00) begin
        chk("R2", "sinkData", sinkData, 32'h9E37_79B9 * (id + 3));
        chk("R2", "sinkId", {25'b0, sinkId}, id);
      end
    end
    @(negedge clk);
    inValid = 1'b0; sinkReady = 2'b11;
  endtask

  initial begin
    logic [31:0] d;
    expMask[0] = '0; expMask[1] = '0; expLocked = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readAll("R1");
    sweepIds(2'b11);

    // R7: writes while locked from reset are dropped
    apbWrite(12'h0F8, 32'hFFFF_FFFF);
    apbWrite(12'h10C, 32'h1234_5678);
    readAll("R7");

    // R5 + R3: unlock, fill masks with computed patterns
    apbWrite(12'hFB0, Key);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        apbWrite(12'(12'h0F8 + 16 * s + 4 * w), 32'h6A09_E667 * (s * 4 + w + 1));
    readAll("R3");
    for (int r = 0; r < 4; r++) sweepIds(2'(3 - r));

    // R3: single ID 5 lives in bit 5 of sink 0 word 0
    apbWrite(12'h0F8, 32'h0000_0020);
    apbRead(12'h0F8, d);
    chk("R3", "id5 word", d, 32'h20);
    sweepIds(2'b11);

    // R4: unmapped reads and writes
    apbRead(12'h0F4, d); chk("R4", "read 0F4", d, 0);
    apbRead(12'h118, d); chk("R4", "read 118", d, 0);
    apbRead(12'h0FA, d); chk("R4", "read 0FA", d, 0);
    apbRead(12'h000, d); chk("R4", "read 000", d, 0);
    apbRead(12'hFB0, d); chk("R4", "read FB0", d, 0);
    apbWrite(12'h0F4, 32'hDEAD_BEEF);
    apbWrite(12'h118, 32'hDEAD_BEEF);
    apbWrite(12'h0FA, 32'hDEAD_BEEF);
    readAll("R4");

    // R5/R7: relock with wrong key, write ignored; unlock again, write lands
    apbWrite(12'hFB0, 32'h0000_1234);
    apbWrite(12'h0F8, 32'hFFFF_FFFF);
    apbRead(12'h0F8, d); chk("R7", "locked write", d, 32'h20);
    apbWrite(12'hFB0, Key);
    apbWrite(12'h0F8, 32'hFFFF_FFFF);
    apbRead(12'h0F8, d); chk("R5", "unlocked write", d, 32'hFFFF_FFFF);

    // R9: write and beat in the same cycle
    apbWrite(12'h10C, 32'h0);
    @(negedge clk);
    inValid = 1'b1; inId = 7'd40; inData = 32'hCAFE_0040; sinkReady = 2'b11;
    pSel = 1'b1; pWrite = 1'b1; pAddr = 12'h10C; pWdata = 32'h0000_0100; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    #1;
    chk("R9", "old mask during access", {31'b0, sinkValid[1]}, 0);
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
    modelWrite(12'h10C, 32'h0000_0100);
    #1;
    chk("R9", "new mask after access", {31'b0, sinkValid[1]}, 1);
    @(negedge clk);
    inValid = 1'b0;
    sweepIds(2'b01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule